// File: doc/BRIEF.md
# Subword ALU with Scaling Shifters

This block is a 16-bit arithmetic and logic unit. It adds, subtracts, takes absolute values and applies bitwise logic. The arithmetic runs on a 40-bit parallel-prefix adder, which leaves headroom for long running sums kept in an internal 40-bit accumulator. One control bit cuts the carry tree into two independent segments. Each segment carries one 8-bit lane, so the word is processed as two signed bytes. A scaling shifter on the first operand and a second scaling shifter on the wide result each move data by 0, 1, 2 or 4 places, to the left or arithmetically to the right. An optional clamp then limits the result to the signed output range within the same computation cycle.

All controls and operands are captured into an operand register when `en` is high, and they are held there while `en` is low. This keeps the datapath quiet between operations. The result register `y` and the accumulator are updated on the next clock edge, so `y` shows a result two rising edges after the cycle in which `en` was sampled high. A host pulses `en` once per operation and reads `y` (and `acc` for accumulation) afterwards.

Top module: `subword_alu`

## Requirements
- R1: A synchronous active-high reset clears `y` and `acc` to zero.
- R2: Operands and controls are captured only on edges where `en` is high. While `en` is low, input changes leave `y` and `acc` unchanged.
- R3: With `op` 0 (add) or 1 (subtract, computed as inverted `b` plus one), `swp`=0 and `sat_en`=0, `y` is the low 16 bits of a+b or a-b. It appears two rising edges after `en` is sampled.
- R4: With `swp`=1, bits [15:8] and [7:0] form two signed 8-bit lanes. No carry or borrow passes between them, and each lane wraps on its own.
- R5: With `sat_en`=1 and `swp`=0, an add or subtract result outside -32768..32767 is clamped to 0x8000 or 0x7FFF.
- R6: With `sat_en`=1 and `swp`=1, each lane is clamped on its own to -128..127 (0x80 or 0x7F).
- R7: `op` 2 returns the absolute value of the shifted `a`, per lane when `swp`=1. The result is always clamped, so 0x8000 gives 0x7FFF and a lane of 0x80 gives 0x7F.
- R8: `op` 3, 4 and 5 give the bitwise AND, OR and XOR of the shifted `a` with `b`. `op` 6 gives the bitwise inverse of the shifted `a`.
- R9: `in_shamt` codes 0, 1, 2 and 3 shift `a` by 0, 1, 2 and 4 places. `in_right`=0 shifts left and `in_right`=1 shifts arithmetically right. With `swp`=1, each 8-bit lane is shifted on its own.
- R10: `out_shamt` and `out_right`, with the same encoding as the input shifter, scale the wide result before clamping or truncation.
- R11: `op` 7 adds the sign-extended, shifted 16-bit `a` to the 40-bit accumulator and ignores `swp`. `y` is the new accumulator value after output scaling, clamped or truncated to 16 bits.
- R12: `acc_clr` clears the accumulator on the next edge and takes priority over an accumulation on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Capture operands and controls; start one operation |
| op | input | 3 | Operation code (0 add, 1 sub, 2 abs, 3 and, 4 or, 5 xor, 6 not, 7 accumulate) |
| swp | input | 1 | Two 8-bit lanes instead of one 16-bit word |
| sat_en | input | 1 | Clamp the result to the signed output range |
| in_shamt | input | 2 | Input shift amount code (0, 1, 2, 4 places) |
| in_right | input | 1 | Input shift direction, 1 = arithmetic right |
| out_shamt | input | 2 | Output shift amount code (0, 1, 2, 4 places) |
| out_right | input | 1 | Output shift direction, 1 = arithmetic right |
| acc_clr | input | 1 | Clear the accumulator |
| a | input | 16 | First operand, passes through the input shifter |
| b | input | 16 | Second operand |
| y | output | 16 | Registered result |
| acc | output | 40 | Accumulator contents |

## Verification
The assertions assume that `rst`, `en` and `acc_clr` are always at known levels. They also assume that `op` holds a defined code in any cycle where `en` is high, since the checker looks two cycles back at the operation that was captured. The stimulus changes every input only at the falling clock edge. It raises `en` for exactly one cycle per operation and then waits for the result edge, so a captured operation and its result update never overlap with the next capture. Accumulator tests change `acc_clr` the same way: it is held high across both the capture edge and the result edge only when the clear-over-accumulate priority is under test.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_ABS = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_XOR = 3'd5,
    OP_NOT = 3'd6,
    OP_ACC = 3'd7
  } alu_op_e;

  // shift code 0,1,2,3 -> 0,1,2,4 places
  function automatic logic [2:0] shamt_decode(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd0;
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/scale_shifter.sv
module scale_shifter import alu_pkg::*; #(
  parameter int W = 16
) (
  input  logic [W-1:0] d,
  input  logic [1:0]   code,
  input  logic         right,
  output logic [W-1:0] q
);
  logic [2:0] amt;
  assign amt = shamt_decode(code);
  assign q = right ? W'($signed(d) >>> amt) : (d << amt);
endmodule

// File: rtl/prefix_adder.sv
module prefix_adder #(
  parameter int W     = 40,
  parameter int SEGS  = 2
) (
  input  logic [W-1:0]    x,
  input  logic [W-1:0]    y,
  input  logic [SEGS-1:0] cin,
  input  logic            split,
  output logic [W-1:0]    sum
);
  localparam int LV    = $clog2(W);
  localparam int SEG_W = W / SEGS;

  logic [W-1:0] half, grp_g, grp_p, carry;

  assign half = x ^ y;

  always_comb begin
    logic [W-1:0] g, p, ng, np;
    g = x & y;
    p = half;
    // cut the tree: the top bit of each lower segment injects the next segment's carry-in
    if (split) begin
      for (int k = 1; k < SEGS; k++) begin
        g[k*SEG_W-1] = cin[k];
        p[k*SEG_W-1] = 1'b0;
      end
    end
    for (int l = 0; l < LV; l++) begin
      ng = g;
      np = p;
      for (int i = 0; i < W; i++) begin
        if (((i >> l) & 1) == 1) begin
          int j;
          j = ((i >> (l + 1)) << (l + 1)) + (1 << l) - 1;
          ng[i] = g[i] | (p[i] & g[j]);
          np[i] = p[i] & p[j];
        end
      end
      g = ng;
      p = np;
    end
    grp_g = g;
    grp_p = p;
  end

  assign carry = {grp_g[W-2:0] | (grp_p[W-2:0] & {(W-1){cin[0]}}), cin[0]};
  assign sum   = half ^ carry;
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int IW = 40,
  parameter int OW = 16
) (
  input  logic [IW-1:0] d,
  input  logic          sat,
  output logic [OW-1:0] q
);
  logic ovf;
  // value fits only when every bit from the output sign upward agrees
  assign ovf = !(&d[IW-1:OW-1]) && (|d[IW-1:OW-1]);
  always_comb begin
    if (sat && ovf) q = d[IW-1] ? {1'b1, {(OW-1){1'b0}}} : {1'b0, {(OW-1){1'b1}}};
    else            q = d[OW-1:0];
  end
endmodule

// File: rtl/subword_alu.sv
module subword_alu import alu_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [2:0]        op,
  input  logic              swp,
  input  logic              sat_en,
  input  logic [1:0]        in_shamt,
  input  logic              in_right,
  input  logic [1:0]        out_shamt,
  input  logic              out_right,
  input  logic              acc_clr,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic [ACC_W-1:0]  acc
);
  localparam int LANE_W = DATA_W / LANES;
  localparam int SEG_W  = ACC_W / LANES;

  // operand register: holds still while en is low
  alu_op_e           op_q;
  logic              swp_q, sat_q, isr_q, osr_q, v_q;
  logic [1:0]        isc_q, osc_q;
  logic [DATA_W-1:0] a_q, b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= OP_ADD; swp_q <= 1'b0; sat_q <= 1'b0; isr_q <= 1'b0; osr_q <= 1'b0;
      isc_q <= '0; osc_q <= '0; a_q <= '0; b_q <= '0; v_q <= 1'b0;
    end else begin
      v_q <= en;
      if (en) begin
        op_q <= alu_op_e'(op); swp_q <= swp; sat_q <= sat_en;
        isc_q <= in_shamt; isr_q <= in_right; osc_q <= out_shamt; osr_q <= out_right;
        a_q <= a; b_q <= b;
      end
    end
  end

  logic use_lanes;
  assign use_lanes = swp_q && (op_q != OP_ACC);

  // input scaling: whole word and per lane
  logic [DATA_W-1:0] as_full, as_lane, as_v;
  scale_shifter #(.W(DATA_W)) u_ish_full (.d(a_q), .code(isc_q), .right(isr_q), .q(as_full));

  // output scaling and clamping share the per-lane structure
  logic [ACC_W-1:0]  wide, os_full, os_lane;
  logic [DATA_W-1:0] res_full, res_lane, res;
  logic              do_sat;
  assign do_sat = sat_q || (op_q == OP_ABS);

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      scale_shifter #(.W(LANE_W)) u_ish (
        .d(a_q[k*LANE_W +: LANE_W]), .code(isc_q), .right(isr_q),
        .q(as_lane[k*LANE_W +: LANE_W]));
      scale_shifter #(.W(SEG_W)) u_osh (
        .d(wide[k*SEG_W +: SEG_W]), .code(osc_q), .right(osr_q),
        .q(os_lane[k*SEG_W +: SEG_W]));
      sat_clamp #(.IW(SEG_W), .OW(LANE_W)) u_clamp (
        .d(os_lane[k*SEG_W +: SEG_W]), .sat(do_sat),
        .q(res_lane[k*LANE_W +: LANE_W]));
    end
  endgenerate

  assign as_v = use_lanes ? as_lane : as_full;

  function automatic logic [ACC_W-1:0] widen(input logic [DATA_W-1:0] v, input logic lanes);
    logic [ACC_W-1:0] r;
    if (lanes) begin
      for (int i = 0; i < LANES; i++)
        r[i*SEG_W +: SEG_W] = SEG_W'($signed(v[i*LANE_W +: LANE_W]));
    end else begin
      r = ACC_W'($signed(v));
    end
    return r;
  endfunction

  // operand selection for the adder
  logic [ACC_W-1:0]  add_x, add_y, sum, inv_mask;
  logic [LANES-1:0]  cin, neg;
  logic [DATA_W-1:0] logic_r;
  logic              is_logic;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      neg[i] = use_lanes ? as_v[i*LANE_W+LANE_W-1] : as_v[DATA_W-1];
      inv_mask[i*SEG_W +: SEG_W] = {SEG_W{neg[i]}};
    end
    add_x = widen(as_v, use_lanes);
    add_y = widen(b_q, use_lanes);
    cin   = '0;
    case (op_q)
      OP_SUB: begin add_y = ~add_y; cin = '1; end
      OP_ABS: begin add_y = add_x ^ inv_mask; add_x = '0; cin = neg; end
      OP_ACC: begin add_x = acc; add_y = ACC_W'($signed(as_full)); end
      default: ;
    endcase
    is_logic = 1'b1;
    case (op_q)
      OP_AND:  logic_r = as_v & b_q;
      OP_OR:   logic_r = as_v | b_q;
      OP_XOR:  logic_r = as_v ^ b_q;
      OP_NOT:  logic_r = ~as_v;
      default: begin logic_r = '0; is_logic = 1'b0; end
    endcase
  end

  prefix_adder #(.W(ACC_W), .SEGS(LANES)) u_add (
    .x(add_x), .y(add_y), .cin(cin), .split(use_lanes), .sum(sum));

  assign wide = is_logic ? widen(logic_r, use_lanes) : sum;

  scale_shifter #(.W(ACC_W)) u_osh_full (.d(wide), .code(osc_q), .right(osr_q), .q(os_full));
  sat_clamp #(.IW(ACC_W), .OW(DATA_W)) u_clamp_full (.d(os_full), .sat(do_sat), .q(res_full));

  assign res = use_lanes ? res_lane : res_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      y   <= '0;
      acc <= '0;
    end else begin
      if (v_q) y <= res;
      if (acc_clr)                    acc <= '0;
      else if (v_q && op_q == OP_ACC) acc <= sum;
    end
  end
endmodule

// File: rtl/subword_alu_chk.sv
module subword_alu_chk #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [2:0]        op,
  input logic              swp,
  input logic              acc_clr,
  input logic [DATA_W-1:0] y,
  input logic [ACC_W-1:0]  acc
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (y == '0 && acc == '0));

  // R2
  hold_y_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en, 2)) |-> $stable(y));

  // R2
  hold_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(acc_clr) && !($past(en, 2) && $past(op, 2) == 3'd7)) |-> $stable(acc));

  // R12
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(acc_clr) |-> acc == '0);

  // R7
  abs_nonneg_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en, 2) && $past(op, 2) == 3'd2 && !$past(rst)) |->
      (!y[DATA_W-1] && (!$past(swp, 2) || !y[DATA_W/2-1])));
endmodule

bind subword_alu subword_alu_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (.*);

// File: tb/subword_alu_test.sv
module subword_alu_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  op;
    logic        swp;
    logic        sat;
    logic [1:0]  isc;
    logic        isr;
    logic [1:0]  osc;
    logic        osr;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 16'h1234, 16'h1111, 16'h2345, 4'd3},  // R3 add
    '{3'd1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 16'h0005, 16'h0007, 16'hFFFE, 4'd3},  // R3 sub
    '{3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 4'd3},  // R3 wrap
    '{3'd0, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 16'h7FFF, 16'h0001, 16'h7FFF, 4'd5},  // R5 high
    '{3'd1, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 16'h8000, 16'h0001, 16'h8000, 4'd5},  // R5 low
    '{3'd0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 16'h01FF, 16'h0101, 16'h0200, 4'd4},  // R4 no carry
    '{3'd1, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 16'h0100, 16'h0001, 16'h01FF, 4'd4},  // R4 no borrow
    '{3'd0, 1'b1, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 16'h7F80, 16'h01FF, 16'h7F80, 4'd6},  // R6 add
    '{3'd1, 1'b1, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 16'h8005, 16'h0106, 16'h80FF, 4'd6},  // R6 sub
    '{3'd2, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 16'hFFF6, 16'h0000, 16'h000A, 4'd7},  // R7
    '{3'd2, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 16'h8000, 16'h0000, 16'h7FFF, 4'd7},  // R7 min
    '{3'd2, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 16'h80F6, 16'h0000, 16'h7F0A, 4'd7},  // R7 lanes
    '{3'd3, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 16'hF0F0, 16'h3C3C, 16'h3030, 4'd8},  // R8 and
    '{3'd4, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 16'hF0F0, 16'h0F01, 16'hFFF1, 4'd8},  // R8 or
    '{3'd5, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 16'hFF00, 16'h0FF0, 16'hF0F0, 4'd8},  // R8 xor
    '{3'd6, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 16'h1234, 16'hFFFF, 16'hEDCB, 4'd8},  // R8 not
    '{3'd0, 1'b0, 1'b0, 2'd3, 1'b0, 2'd0, 1'b0, 16'h0003, 16'h0001, 16'h0031, 4'd9},  // R9 left 4
    '{3'd0, 1'b0, 1'b0, 2'd2, 1'b1, 2'd0, 1'b0, 16'hFF00, 16'h0000, 16'hFFC0, 4'd9},  // R9 right 2
    '{3'd0, 1'b1, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, 16'h0181, 16'h0000, 16'h0202, 4'd9},  // R9 lanes
    '{3'd0, 1'b0, 1'b1, 2'd0, 1'b0, 2'd1, 1'b1, 16'h4000, 16'h4000, 16'h4000, 4'd10}, // R10 before clamp
    '{3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd3, 1'b0, 16'h0123, 16'h0000, 16'h1230, 4'd10}  // R10 left 4
  };

  logic        clk = 1'b0;
  logic        rst, en, swp, sat_en, in_right, out_right, acc_clr;
  logic [2:0]  op;
  logic [1:0]  in_shamt, out_shamt;
  logic [15:0] a, b, y;
  logic [39:0] acc;
  int          total = 0;
  int          bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subword_alu uut (
    .clk(clk), .rst(rst), .en(en), .op(op), .swp(swp), .sat_en(sat_en),
    .in_shamt(in_shamt), .in_right(in_right), .out_shamt(out_shamt), .out_right(out_right),
    .acc_clr(acc_clr), .a(a), .b(b), .y(y), .acc(acc));

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic s, input logic st, input logic [1:0] ic,
                        input logic ir, input logic [1:0] oc, input logic orr,
                        input logic [15:0] va, input logic [15:0] vb);
    @(negedge clk);
    op = o; swp = s; sat_en = st; in_shamt = ic; in_right = ir;
    out_shamt = oc; out_right = orr; a = va; b = vb; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; en = 1'b0; op = '0; swp = 1'b0; sat_en = 1'b0; in_shamt = '0; in_right = 1'b0;
    out_shamt = '0; out_right = 1'b0; acc_clr = 1'b0; a = '0; b = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 y after reset", {24'd0, y}, 40'd0);
    check("R1 acc after reset", acc, 40'd0);

    for (int i = 0; i < NV; i++) begin
      run_op(TBL[i].op, TBL[i].swp, TBL[i].sat, TBL[i].isc, TBL[i].isr,
             TBL[i].osc, TBL[i].osr, TBL[i].a, TBL[i].b);
      check($sformatf("R%0d vector %0d", TBL[i].req, i), {24'd0, y}, {24'd0, TBL[i].exp});
    end

    // R2: inputs move while en stays low
    @(negedge clk);
    op = 3'd7; a = 16'h5555; b = 16'hAAAA; swp = 1'b1; sat_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 y held", {24'd0, y}, 40'h1230);
    check("R2 acc held", acc, 40'd0);

    // R11: accumulation with headroom
    run_op(3'd7, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 16'h7FFF, 16'h0000);
    check("R11 acc first", acc, 40'd32767);
    check("R11 y first", {24'd0, y}, 40'h7FFF);
    run_op(3'd7, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 16'h7FFF, 16'h0000);
    check("R11 acc beyond 16 bits", acc, 40'd65534);
    check("R11 y clamped", {24'd0, y}, 40'h7FFF);
    run_op(3'd7, 1'b0, 1'b0, 2'd0, 1'b0, 2'd1, 1'b1, 16'h8000, 16'h0000);
    check("R11 acc negative add", acc, 40'd32766);
    check("R10 R11 y scaled", {24'd0, y}, 40'h3FFF);
    run_op(3'd7, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 16'h0101, 16'h0000);
    check("R11 acc ignores swp", acc, 40'd33023);
    check("R11 y truncated", {24'd0, y}, 40'h80FF);

    // R12: clear wins over an accumulate on the same edge
    @(negedge clk);
    op = 3'd7; swp = 1'b0; sat_en = 1'b0; in_shamt = '0; out_shamt = '0;
    a = 16'h0005; en = 1'b1; acc_clr = 1'b1;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    acc_clr = 1'b0;
    check("R12 clear priority", acc, 40'd0);
    run_op(3'd7, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 16'h0009, 16'h0000);
    check("R12 accumulate after clear", acc, 40'd9);

    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 y after mid-run reset", {24'd0, y}, 40'd0);
    check("R1 acc after mid-run reset", acc, 40'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule